// File: doc/BRIEF.md
# Cache ECC Error Capture Bank

This block sits beside a last-level cache and records the error-correction events that the cache's checkers report. Four independent sources feed it: corrected and uncorrectable errors in the directory, and corrected and uncorrectable errors in the data array. Each source reports an event as a one-cycle pulse with a 64-bit address. For each source the block keeps the address of the latest event, a saturating event count and a level interrupt.

Software services an interrupt by reading the captured address through a 32-bit read port, as a low word and a high word, and then reading the source's count word. Reading the count word is the acknowledge: it drops that source's interrupt. Reading an address word changes no state. Read data is registered and returned in the cycle after the request.

Top module: `ecc_err_bank`

## Requirements
- R1: After reset every interrupt output is 0 and every mapped register reads 0.
- R2: Read data appears on `rd_data_o` in the cycle after `rd_en_i` is sampled high. The register offsets are: source 0 (directory corrected) at 0x100/0x104/0x108, source 3 (directory uncorrectable) at 0x120/0x124/0x128, source 1 (data corrected) at 0x140/0x144/0x148, and source 2 (data uncorrectable) at 0x160/0x164/0x168. At each base, +0 holds address bits 31:0, +4 holds address bits 63:32 and +8 holds the count, zero-extended.
- R3: A source's count saturates at all ones. A further event leaves it at that value.
- R4: Each event increments its source's count by exactly one. Without an event the count does not change.
- R5: An event on `evt_valid_i[i]` drives `irq_o[i]` high from the next cycle.
- R6: A read of a source's count word clears that source's interrupt at the same edge. The only exception is an event from the same source in that same cycle, which keeps the interrupt high.
- R7: Reading an address word leaves the interrupt and the count unchanged.
- R8: The address words of a source hold the address of that source's most recent event.
- R9: Unmapped offsets read 0, and `rd_data_o` is 0 in any cycle that follows a cycle with no read request.
- R10: Events on several sources in the same cycle are each recorded in their own source, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 4 | One event pulse per source, indexed by interrupt number |
| evt_addr_i | input | 256 | Event addresses; source i uses bits [64*i+63:64*i] |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 12 | Byte offset of the register to read |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 4 | Per-source interrupt, level high |

## Verification
The hardest case to reach is an acknowledge read that meets a new event from the same source at the same edge. Only this case shows whether a clear-then-set ordering can lose an event. The bench drives both the event pulse and the count read on the same falling edge. It then checks three things: the interrupt stays high, the read returns the old count, and a second read returns the new count and clears the interrupt. Saturation is reached with the counter width reduced to 4 bits through its parameter.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int unsigned NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_DIR_FIX = 2'd0,
    SRC_DAT_FIX = 2'd1,
    SRC_DAT_BAD = 2'd2,
    SRC_DIR_BAD = 2'd3
  } ecc_src_e;

  localparam logic [8:0] OFF_LO  = 9'h000;
  localparam logic [8:0] OFF_HI  = 9'h004;
  localparam logic [8:0] OFF_CNT = 9'h008;

  // base offset of each source window, indexed by interrupt number
  function automatic logic [8:0] src_base(input int unsigned idx);
    case (idx)
      0:       return 9'h100;
      1:       return 9'h140;
      2:       return 9'h160;
      default: return 9'h120;
    endcase
  endfunction
endpackage

// File: rtl/ecc_src_slot.sv
module ecc_src_slot #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic              cnt_rd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (evt_i) begin
        addr_q <= evt_addr_i;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      // set wins over clear so a colliding event is not lost
      irq_q <= evt_i | (irq_q & ~cnt_rd_i);
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ecc_rd_decode.sv
module ecc_rd_decode
  import ecc_err_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [N_SRC-1:0] lo_sel_o,
  output logic [N_SRC-1:0] hi_sel_o,
  output logic [N_SRC-1:0] cnt_sel_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_dec
    localparam logic [AW-1:0] A_LO  = AW'(src_base(i) + OFF_LO);
    localparam logic [AW-1:0] A_HI  = AW'(src_base(i) + OFF_HI);
    localparam logic [AW-1:0] A_CNT = AW'(src_base(i) + OFF_CNT);
    assign lo_sel_o[i]  = rd_en_i && (rd_addr_i == A_LO);
    assign hi_sel_o[i]  = rd_en_i && (rd_addr_i == A_HI);
    assign cnt_sel_o[i] = rd_en_i && (rd_addr_i == A_CNT);
  end
endmodule

// File: rtl/ecc_err_bank.sv
module ecc_err_bank
  import ecc_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned AW     = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0]            evt_valid_i,
  input  logic [NUM_SRC*2*DATA_W-1:0]   evt_addr_i,
  input  logic                          rd_en_i,
  input  logic [AW-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [NUM_SRC-1:0]            irq_o
);
  localparam int unsigned ADDR_W = 2 * DATA_W;

  logic [NUM_SRC-1:0]             lo_sel, hi_sel, cnt_sel;
  logic [NUM_SRC-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_SRC-1:0][CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0]              rd_mux;

  ecc_rd_decode #(.AW(AW), .N_SRC(NUM_SRC)) u_dec (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .lo_sel_o  (lo_sel),
    .hi_sel_o  (hi_sel),
    .cnt_sel_o (cnt_sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    ecc_src_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_valid_i[i]),
      .evt_addr_i (evt_addr_i[i*ADDR_W +: ADDR_W]),
      .cnt_rd_i   (cnt_sel[i]),
      .addr_o     (addr_q[i]),
      .cnt_o      (cnt_q[i]),
      .irq_o      (irq_o[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (lo_sel[i])  rd_mux |= addr_q[i][DATA_W-1:0];
      if (hi_sel[i])  rd_mux |= addr_q[i][ADDR_W-1:DATA_W];
      if (cnt_sel[i]) rd_mux |= DATA_W'(cnt_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/ecc_err_bank_chk.sv
module ecc_err_bank_chk
  import ecc_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned AW     = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_SRC-1:0]            evt_valid_i,
  input logic                          rd_en_i,
  input logic [AW-1:0]                 rd_addr_i,
  input logic [DATA_W-1:0]             rd_data_o,
  input logic [NUM_SRC-1:0]            irq_o,
  input logic [NUM_SRC-1:0][CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    localparam logic [AW-1:0] A_CNT = AW'(src_base(i) + OFF_CNT);
    logic ack;
    assign ack = rd_en_i && (rd_addr_i == A_CNT);

    a_r5_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_valid_i[i] |=> irq_o[i]);
    a_r6_irq_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack && !evt_valid_i[i] |=> !irq_o[i]);
    a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack && !evt_valid_i[i] |=> $stable(irq_o[i]));
    a_r4_cnt_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_valid_i[i] && cnt_q[i] != CMAX |=> cnt_q[i] == CNT_W'($past(cnt_q[i]) + 1'b1));
    a_r4_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !evt_valid_i[i] |=> $stable(cnt_q[i]));
    a_r3_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_valid_i[i] && cnt_q[i] == CMAX |=> cnt_q[i] == CMAX);
  end

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rd_data_o == '0);
endmodule

bind ecc_err_bank ecc_err_bank_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .cnt_q       (cnt_q)
);

// File: tb/test_ecc_err_bank.sv
module test_ecc_err_bank;
  localparam int CW = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   evt_valid_i = '0;
  logic [255:0] evt_addr_i = '0;
  logic         rd_en_i = 1'b0;
  logic [11:0]  rd_addr_i = '0;
  logic [31:0]  rd_data_o;
  logic [3:0]   irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  ecc_err_bank #(.DATA_W(32), .CNT_W(CW), .AW(12)) i_ecc_err_bank (
    .clk_i, .rst_ni, .evt_valid_i, .evt_addr_i,
    .rd_en_i, .rd_addr_i, .rd_data_o, .irq_o
  );

  typedef struct packed {
    logic [1:0]  src;
    logic [63:0] addr;
    logic [31:0] cnt;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 64'h0000_0001_0000_0040, 32'd1},
    '{2'd1, 64'h8000_0000_1234_5678, 32'd1},
    '{2'd2, 64'hDEAD_BEEF_CAFE_F00D, 32'd1},
    '{2'd3, 64'h0000_00FF_FFFF_FFC0, 32'd1},
    '{2'd0, 64'h1111_2222_3333_4444, 32'd2},
    '{2'd2, 64'h0000_0000_0000_0000, 32'd2},
    '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'd3},
    '{2'd1, 64'h0A0B_0C0D_0E0F_1011, 32'd2}
  };

  function automatic logic [11:0] base_of(input int s);
    case (s)
      0: return 12'h100;
      1: return 12'h140;
      2: return 12'h160;
      default: return 12'h120;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic fire(input logic [3:0] m, input logic [255:0] a);
    @(negedge clk_i);
    evt_valid_i = m; evt_addr_i = a;
    @(negedge clk_i);
    evt_valid_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [255:0] a;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    check("R1 irq", 64'(irq_o), 64'h0);
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 3; w++) begin
        rd(base_of(s) + 12'(4*w), d);
        check("R1 reg", 64'(d), 64'h0);
      end

    // vector table: event, then read lo/hi/count
    for (int k = 0; k < 8; k++) begin
      a = '0;
      a[VEC[k].src*64 +: 64] = VEC[k].addr;
      fire(4'b1 << VEC[k].src, a);
      check("R5 irq set", 64'(irq_o[VEC[k].src]), 64'h1);
      rd(base_of(VEC[k].src), d);
      check("R8 addr lo", 64'(d), 64'(VEC[k].addr[31:0]));
      rd(base_of(VEC[k].src) + 12'h4, d);
      check("R2 addr hi", 64'(d), 64'(VEC[k].addr[63:32]));
      check("R7 irq kept", 64'(irq_o[VEC[k].src]), 64'h1);
      rd(base_of(VEC[k].src) + 12'h8, d);
      check("R4 count", 64'(d), 64'(VEC[k].cnt));
      check("R6 irq cleared", 64'(irq_o[VEC[k].src]), 64'h0);
    end

    // R3: saturation on source 3 (count 1 + 20 events)
    for (int k = 0; k < 20; k++) fire(4'b1000, {64'h55, 192'h0});
    rd(12'h128, d);
    check("R3 saturated", 64'(d), 64'd15);

    // R10: all sources at once
    a = {64'h3333_0000_0000_0003, 64'h2222_0000_0000_0002,
         64'h1111_0000_0000_0001, 64'h0000_0000_0000_0000};
    fire(4'hF, a);
    check("R10 irqs", 64'(irq_o), 64'hF);
    for (int s = 0; s < 4; s++) begin
      rd(base_of(s) + 12'h4, d);
      check("R10 addr hi", 64'(d), 64'(a[s*64+32 +: 32]));
    end
    rd(12'h108, d); check("R10 cnt src0", 64'(d), 64'd4);
    rd(12'h148, d); check("R10 cnt src1", 64'(d), 64'd3);
    rd(12'h168, d); check("R10 cnt src2", 64'(d), 64'd3);
    rd(12'h128, d); check("R10 cnt src3", 64'(d), 64'd15);
    check("R6 all cleared", 64'(irq_o), 64'h0);

    // R6: event on source 1 in the same cycle as its count read
    @(negedge clk_i);
    evt_valid_i = 4'b0010; evt_addr_i = {128'h0, 64'h77, 64'h0};
    rd_en_i = 1'b1; rd_addr_i = 12'h148;
    @(negedge clk_i);
    evt_valid_i = '0; rd_en_i = 1'b0;
    check("R6 collide old count", 64'(rd_data_o), 64'd3);
    check("R6 collide irq kept", 64'(irq_o[1]), 64'h1);
    rd(12'h148, d);
    check("R6 new count", 64'(d), 64'd4);
    check("R6 irq cleared after", 64'(irq_o[1]), 64'h0);

    // R9: unmapped offsets and idle bus
    rd(12'h10C, d); check("R9 unmapped 10C", 64'(d), 64'h0);
    rd(12'h000, d); check("R9 unmapped 000", 64'(d), 64'h0);
    rd(12'h180, d); check("R9 unmapped 180", 64'(d), 64'h0);
    rd(12'h144, d);
    @(negedge clk_i);
    check("R9 idle zero", 64'(rd_data_o), 64'h0);

    // R1: reset mid-run clears state
    fire(4'b0100, {64'h0, 64'h9, 128'h0});
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    check("R1 irq after reset", 64'(irq_o), 64'h0);
    rd(12'h168, d); check("R1 count after reset", 64'(d), 64'h0);
    rd(12'h160, d); check("R1 addr after reset", 64'(d), 64'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule